// File: doc/BRIEF.md
# Per-Port Interrupt Status Aggregator

This block merges interrupt events from several device ports into one interrupt line toward the host. Behind that line sits a three-level status hierarchy. A global status register holds one irq bit. A summary register has one bit per port. Each port has a queue status register with an irq flag, a descriptor-completion flag and an error flag. Each port also has a software-written acknowledge pointer register. The descriptor-completion flag compares that register with the hardware extract pointer supplied by the prefetch engine.

The prefetch engine pulses a per-port event input when a response has gone out. It pulses a per-port error input when a fetch was terminated by a fault. Either pulse raises the port's queue irq flag, and the summary bit, the global bit and the output line follow from it. Software reads the global bit and then the summary register to find the port to service. It writes the port's acknowledge pointer, then clears the queue irq flag by writing a 1 to it. All registers share one word-addressed access port. Writes take effect on the clock edge. Read data follows the address combinationally.

Register map (word addresses): 0 is global status (bit 0 = irq). 1 is the summary (bit p = port p). 2+2p is the queue status of port p (bit 0 = irq, bit 1 = descriptor completion, bit 2 = error). 3+2p is the acknowledge pointer of port p (low PTR_W bits).

Top module: `irq_agg_top`

## Requirements
- R1: After reset, every queue irq flag, every error flag and every acknowledge pointer is zero. irqOut is low, and global status and summary read as zero.
- R2: A pulse on portEvent[p] sets bit 0 of port p's queue status on the next clock edge. From that edge, summary bit p, global status bit 0 and irqOut all read 1.
- R3: A pulse on portError[p] sets both bit 0 (irq) and bit 2 (error) of port p's queue status on the next edge, so a terminated operation still interrupts.
- R4: Bits 0 and 2 of a queue status register are write-1-to-clear. Writing a 1 clears the bit at the next edge. Writing a 0 leaves it unchanged.
- R5: When an event or error for port p arrives in the same cycle as a software clear of that port's flag, the flag stays set.
- R6: Summary bit p equals port p's queue irq flag. Global status bit 0 and irqOut are the OR of all summary bits, so the line stays high until the last pending port is cleared.
- R7: The acknowledge pointer register of port p stores the low PTR_W bits of a write to address 3+2p. It reads back zero-extended, and writes to other addresses leave it unchanged.
- R8: Bit 1 of port p's queue status reads 1 exactly when hwExtractPtr slice p differs from port p's acknowledge pointer, and it follows either value with no added clock delay.
- R9: Writes to the global status and summary addresses have no effect, and reads of addresses at or above 2+2*NUM_PORTS return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | ADDR_W | Word address of the register access |
| regWrEn | input | 1 | Write strobe for the addressed register |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data of the addressed register |
| portEvent | input | NUM_PORTS | Per-port completion event pulses |
| portError | input | NUM_PORTS | Per-port fetch-error termination pulses |
| hwExtractPtr | input | NUM_PORTS*PTR_W | Hardware extract pointer of each port, packed |
| irqOut | output | 1 | Combined host interrupt line |

## Verification
Every single-port event is applied, and then every one of the sixteen event masks, to show that the summary register names exactly the raised ports. The masks also show that the line stays high through partial clears and drops only after the last one. Error pulses are applied apart from completion events, which separates the error flag from the irq flag and checks that each clears on its own. An event that collides with a clear of the same flag shows which one takes priority. A full sweep of one port's acknowledge pointer, with a fixed hardware pointer, finds the single value at which the completion flag drops. Moving the hardware pointer then shows that the flag follows it with no delay.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int IDX_W = 8;

  // queue status bit positions (software decodes these)
  localparam int QS_IRQ_BIT  = 0;
  localparam int QS_DONE_BIT = 1;
  localparam int QS_ERR_BIT  = 2;

  localparam int GLOBAL_ADDR  = 0;
  localparam int SUMMARY_ADDR = 1;
  localparam int QUEUE_BASE   = 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_GLOBAL,
    SEL_SUMMARY,
    SEL_QSTAT,
    SEL_ACK
  } regSel_e;

  typedef struct packed {
    regSel_e          sel;
    logic [IDX_W-1:0] port;
    logic             wrStatus;
    logic             wrAck;
  } regStrobe_t;

endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 4
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output regStrobe_t        strobe
);

  localparam int QUEUE_END = QUEUE_BASE + 2 * NUM_PORTS;

  logic [ADDR_W-1:0] offs;

  always_comb begin
    strobe     = '0;
    strobe.sel = SEL_NONE;
    offs       = '0;
    if (regAddr == ADDR_W'(GLOBAL_ADDR)) begin
      strobe.sel = SEL_GLOBAL;
    end else if (regAddr == ADDR_W'(SUMMARY_ADDR)) begin
      strobe.sel = SEL_SUMMARY;
    end else if (int'(regAddr) < QUEUE_END) begin
      offs        = regAddr - ADDR_W'(QUEUE_BASE);
      strobe.port = IDX_W'(offs >> 1);
      strobe.sel  = offs[0] ? SEL_ACK : SEL_QSTAT;
    end
    strobe.wrStatus = regWrEn && (strobe.sel == SEL_QSTAT);
    strobe.wrAck    = regWrEn && (strobe.sel == SEL_ACK);
  end

endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PTR_W     = 8,
  parameter int DATA_W    = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  regStrobe_t                 strobe,
  input  logic [DATA_W-1:0]          wrData,
  input  logic [NUM_PORTS-1:0]       portEvent,
  input  logic [NUM_PORTS-1:0]       portError,
  input  logic [NUM_PORTS*PTR_W-1:0] hwPtrFlat,
  output logic [DATA_W-1:0]          rdData,
  output logic                       irqOut,
  output logic [NUM_PORTS-1:0]       qIrqVec,
  output logic [NUM_PORTS-1:0]       errVec,
  output logic [NUM_PORTS*PTR_W-1:0] ackFlat
);

  logic [NUM_PORTS-1:0] doneVec;
  logic [NUM_PORTS-1:0] summaryVec;
  logic                 globalIrq;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic hit;
    logic raise;
    assign hit   = (strobe.port == IDX_W'(p));
    assign raise = portEvent[p] | portError[p];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        qIrqVec[p] <= 1'b0;
      end else if (raise) begin
        qIrqVec[p] <= 1'b1;
      end else if (strobe.wrStatus && hit && wrData[QS_IRQ_BIT]) begin
        qIrqVec[p] <= 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        errVec[p] <= 1'b0;
      end else if (portError[p]) begin
        errVec[p] <= 1'b1;
      end else if (strobe.wrStatus && hit && wrData[QS_ERR_BIT]) begin
        errVec[p] <= 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ackFlat[p*PTR_W +: PTR_W] <= '0;
      end else if (strobe.wrAck && hit) begin
        ackFlat[p*PTR_W +: PTR_W] <= wrData[PTR_W-1:0];
      end
    end

    assign doneVec[p] = (hwPtrFlat[p*PTR_W +: PTR_W] != ackFlat[p*PTR_W +: PTR_W]);
  end

  // one queue per port: the summary bit is that queue's irq flag
  assign summaryVec = qIrqVec;
  assign globalIrq  = |summaryVec;
  assign irqOut     = globalIrq;

  always_comb begin
    rdData = '0;
    case (strobe.sel)
      SEL_GLOBAL:  rdData[0] = globalIrq;
      SEL_SUMMARY: rdData[NUM_PORTS-1:0] = summaryVec;
      SEL_QSTAT: begin
        for (int p = 0; p < NUM_PORTS; p++) begin
          if (strobe.port == IDX_W'(p)) begin
            rdData[QS_IRQ_BIT]  = qIrqVec[p];
            rdData[QS_DONE_BIT] = doneVec[p];
            rdData[QS_ERR_BIT]  = errVec[p];
          end
        end
      end
      SEL_ACK: begin
        for (int p = 0; p < NUM_PORTS; p++) begin
          if (strobe.port == IDX_W'(p)) begin
            rdData[PTR_W-1:0] = ackFlat[p*PTR_W +: PTR_W];
          end
        end
      end
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PTR_W     = 8,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = $clog2(QUEUE_BASE + 2 * NUM_PORTS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ADDR_W-1:0]          regAddr,
  input  logic                       regWrEn,
  input  logic [DATA_W-1:0]          regWrData,
  output logic [DATA_W-1:0]          regRdData,
  input  logic [NUM_PORTS-1:0]       portEvent,
  input  logic [NUM_PORTS-1:0]       portError,
  input  logic [NUM_PORTS*PTR_W-1:0] hwExtractPtr,
  output logic                       irqOut
);

  regStrobe_t                 strobe;
  logic [NUM_PORTS-1:0]       qIrqVec;
  logic [NUM_PORTS-1:0]       errVec;
  logic [NUM_PORTS*PTR_W-1:0] ackFlat;

  irq_agg_ctrl #(
    .NUM_PORTS(NUM_PORTS),
    .ADDR_W   (ADDR_W)
  ) u_ctrl (
    .regAddr(regAddr),
    .regWrEn(regWrEn),
    .strobe (strobe)
  );

  irq_agg_datapath #(
    .NUM_PORTS(NUM_PORTS),
    .PTR_W    (PTR_W),
    .DATA_W   (DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (regWrData),
    .portEvent(portEvent),
    .portError(portError),
    .hwPtrFlat(hwExtractPtr),
    .rdData   (regRdData),
    .irqOut   (irqOut),
    .qIrqVec  (qIrqVec),
    .errVec   (errVec),
    .ackFlat  (ackFlat)
  );

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int NUM_PORTS = 4,
  parameter int PTR_W     = 8,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [ADDR_W-1:0]          regAddr,
  input logic                       regWrEn,
  input logic [DATA_W-1:0]          regWrData,
  input logic [NUM_PORTS-1:0]       portEvent,
  input logic [NUM_PORTS-1:0]       portError,
  input logic                       irqOut,
  input logic [NUM_PORTS-1:0]       qIrqVec,
  input logic [NUM_PORTS-1:0]       errVec,
  input logic [NUM_PORTS*PTR_W-1:0] ackFlat
);

  // R6
  line_drop_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> $past(regWrEn));

  // R2
  any_event_raises_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(portEvent | portError)) |=> irqOut);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    // R5
    event_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      (portEvent[p] || portError[p]) |=> qIrqVec[p]);

    // R3
    error_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
      portError[p] |=> (errVec[p] && qIrqVec[p]));

    // R4
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (regWrEn && regAddr == ADDR_W'(2 + 2 * p) && regWrData[0]
       && !portEvent[p] && !portError[p]) |=> !qIrqVec[p]);

    // R7
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(regWrEn && regAddr == ADDR_W'(3 + 2 * p)) |=> $stable(ackFlat[p*PTR_W +: PTR_W]));
  end

endmodule

bind irq_agg_top irq_agg_chk #(
  .NUM_PORTS(NUM_PORTS),
  .PTR_W    (PTR_W),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regAddr  (regAddr),
  .regWrEn  (regWrEn),
  .regWrData(regWrData),
  .portEvent(portEvent),
  .portError(portError),
  .irqOut   (irqOut),
  .qIrqVec  (qIrqVec),
  .errVec   (errVec),
  .ackFlat  (ackFlat)
);

// File: tb/tb_irq_agg_top.sv
module tb_irq_agg_top;

  localparam int NP     = 4;
  localparam int PW     = 8;
  localparam int DW     = 32;
  localparam int AW     = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic          regWrEn = 1'b0;
  logic [DW-1:0] regWrData = '0;
  logic [DW-1:0] regRdData;
  logic [NP-1:0] portEvent = '0;
  logic [NP-1:0] portError = '0;
  logic [NP*PW-1:0] hwExtractPtr = '0;
  logic          irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_agg_top #(.NUM_PORTS(NP), .PTR_W(PW), .DATA_W(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .portEvent(portEvent),
    .portError(portError), .hwExtractPtr(hwExtractPtr), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    regAddr = AW'(a); regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    regAddr = AW'(a);
    #1;
    d = regRdData;
  endtask

  task automatic pulse(input logic [NP-1:0] ev, input logic [NP-1:0] er);
    @(negedge clk);
    portEvent = ev; portError = er;
    @(negedge clk);
    portEvent = '0; portError = '0;
  endtask

  function automatic logic [DW-1:0] qstat(input bit irq, input bit dn, input bit er);
    return DW'({er, dn, irq});
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irqOut", DW'(irqOut), 0);
    rd(0, d); chk("R1 global", d, 0);
    rd(1, d); chk("R1 summary", d, 0);
    for (int p = 0; p < NP; p++) begin
      rd(2 + 2 * p, d); chk("R1 qstat", d, 0);
      rd(3 + 2 * p, d); chk("R1 ack", d, 0);
    end

    // R2 / R4 single-port events
    for (int p = 0; p < NP; p++) begin
      pulse(NP'(1 << p), '0);
      chk("R2 irqOut", DW'(irqOut), 1);
      rd(0, d); chk("R2 global", d, 1);
      rd(1, d); chk("R2 summary", d, DW'(1 << p));
      rd(2 + 2 * p, d); chk("R2 qstat", d, qstat(1, 0, 0));
      wr(2 + 2 * p, 0);
      rd(2 + 2 * p, d); chk("R4 write0 keeps", d, qstat(1, 0, 0));
      wr(2 + 2 * p, 1);
      rd(2 + 2 * p, d); chk("R4 w1c clears", d, 0);
      chk("R4 irqOut low", DW'(irqOut), 0);
    end

    // R6 every event mask, cleared port by port
    for (int m = 0; m < (1 << NP); m++) begin
      logic [NP-1:0] left;
      left = NP'(m);
      pulse(NP'(m), '0);
      rd(1, d); chk("R6 summary mask", d, DW'(m));
      chk("R6 irqOut mask", DW'(irqOut), DW'(m != 0));
      for (int p = 0; p < NP; p++) begin
        if (left[p]) begin
          wr(2 + 2 * p, 1);
          left[p] = 1'b0;
          rd(1, d); chk("R6 summary partial", d, DW'(left));
          rd(0, d); chk("R6 global partial", d, DW'(left != 0));
          chk("R6 irqOut partial", DW'(irqOut), DW'(left != 0));
        end
      end
    end

    // R3 error pulses
    for (int p = 0; p < NP; p++) begin
      pulse('0, NP'(1 << p));
      rd(2 + 2 * p, d); chk("R3 err sets both", d, qstat(1, 0, 1));
      chk("R3 irqOut", DW'(irqOut), 1);
      wr(2 + 2 * p, 1);
      rd(2 + 2 * p, d); chk("R3 err survives irq clear", d, qstat(0, 0, 1));
      chk("R3 irqOut low", DW'(irqOut), 0);
      wr(2 + 2 * p, 4);
      rd(2 + 2 * p, d); chk("R3 err clear", d, 0);
    end

    // R5 collision of event and clear
    for (int p = 0; p < NP; p++) begin
      pulse(NP'(1 << p), '0);
      @(negedge clk);
      regAddr = AW'(2 + 2 * p); regWrData = 32'h5; regWrEn = 1'b1;
      portEvent = NP'(1 << p);
      @(negedge clk);
      regWrEn = 1'b0; portEvent = '0;
      rd(2 + 2 * p, d); chk("R5 event wins", d, qstat(1, 0, 0));
      wr(2 + 2 * p, 1);
    end

    // R7 / R8 acknowledge pointer and completion flag
    for (int p = 0; p < NP; p++) hwExtractPtr[p*PW +: PW] = PW'(8'h40 + p);
    for (int v = 0; v < (1 << PW); v++) begin
      wr(3, DW'(v));
      rd(3, d); chk("R7 ack readback", d, DW'(v));
      rd(2, d); chk("R8 done sweep", d, qstat(0, v != 8'h40, 0));
    end
    wr(5, 32'hABCD_1241);
    rd(5, d); chk("R7 ack truncated", d, 32'h41);
    rd(3, d); chk("R7 other port kept", d, 32'hFF);
    rd(4, d); chk("R8 equal port1", d, 0);
    @(negedge clk); hwExtractPtr[1*PW +: PW] = 8'h42; #1;
    rd(4, d); chk("R8 follows hw ptr", d, qstat(0, 1, 0));
    hwExtractPtr[1*PW +: PW] = 8'h41; #1;
    rd(4, d); chk("R8 back to equal", d, 0);

    // R9 read-only and unmapped addresses
    wr(0, 32'hFFFF_FFFF);
    wr(1, 32'hFFFF_FFFF);
    rd(0, d); chk("R9 global ro", d, 0);
    rd(1, d); chk("R9 summary ro", d, 0);
    chk("R9 irqOut", DW'(irqOut), 0);
    for (int a = 2 + 2 * NP; a < (1 << AW); a++) begin
      wr(a, 32'hFFFF_FFFF);
      rd(a, d); chk("R9 unmapped", d, 0);
    end
    rd(1, d); chk("R9 no side effect", d, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule